// File: doc/BRIEF.md
# Secure Boot Policy Controller

This block decides whether the CPU may leave reset after a boot-time check of the boot image. It keeps the boot policy in registers that survive a soft reset and stand in for nonvolatile storage. That policy has three parts: a boot mode, the length of the checked region, and a reference tag with its update counter. The checked region always begins at address zero, so only its length is stored. After each soft reset the block starts an external tag engine over that region and compares the returned tag with the reference. It then releases the CPU, reports a failure, or keeps the CPU in reset.

Software sends commands one at a time over a valid/response interface. It can define the boot policy, replace the reference tag under a monotonic counter, and close the boot window with a boot-ok or a boot-failure report. A strict mode can be entered once and never left. It freezes the mode and the length but still accepts reference updates, so the image can be replaced. A failed check in strict mode keeps the CPU in reset permanently. The first boot with no reference stored adopts the computed tag as the reference. The stored tag and counter are never visible at the ports. The power-on input `porN` models first initialisation of the nonvolatile content; `rstN` is the soft reset.

Top module: `secure_boot_ctrl`

## Requirements
- R1: After each soft reset the block pulses `macStart` for exactly one cycle. While it does, `macLen` carries the stored region length, which is 0 after power-on and is changed only by an accepted define command (opcode 0).
- R2: In parallel mode (mode 0), `cpuRelease` goes high in the cycle `macStart` is high, before `bootDone` is set.
- R3: In sequential mode (mode 1), `cpuRelease` stays low until `bootDone` is set and then goes high whatever the outcome. On a failed check `bootFailed` is 1 and `keysUsable` is 0.
- R4: A define command with mode 2 (strict) is accepted once. Every later define returns error 1 (locked), and the stored mode and length keep their values.
- R5: In strict mode a reference update (opcode 1) with a higher counter is still accepted, and the next boot is checked against the new tag.
- R6: A failed check in strict mode keeps `cpuRelease` at 0 with no further `macStart`. No command and no soft reset changes this.
- R7: When no reference is stored, the boot passes and the computed tag becomes the reference. A later boot whose tag differs from it fails.
- R8: A reference update is accepted only when its counter is strictly greater than the stored one. An equal or smaller counter returns error 2 (stale) and leaves the reference unchanged.
- R9: Boot-ok (opcode 2) and boot-failure (opcode 3) are accepted only after the check has finished, and only once per boot. At any other time they return error 3 (sequence). An accepted boot-failure sets `bootFailed` to 1 and `keysUsable` to 0.
- R10: The comparison covers every bit of the tag. A difference in the least or the most significant bit alone fails the check.
- R11: A define command with mode 3 returns error 4 (bad mode) and changes nothing.
- R12: In reset, `cpuRelease`, `macStart`, `rspValid` and the status outputs are 0. Every command is answered by exactly one `rspValid` pulse in the cycle after it, with error code 0 when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, clears the persistent policy |
| rstN | input | 1 | Soft reset, active low, restarts the boot check |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | Opcode: 0 define, 1 update reference, 2 boot-ok, 3 boot-failure |
| cmdMode | input | 2 | Boot mode for define: 0 parallel, 1 sequential, 2 strict |
| cmdSize | input | SIZE_W | Region length for define |
| cmdTag | input | TAG_W | New reference tag for update |
| cmdCount | input | CNT_W | Update counter for update |
| rspValid | output | 1 | Response strobe, one cycle after a command |
| rspErr | output | 3 | Result: 0 ok, 1 locked, 2 stale, 3 sequence, 4 bad mode |
| macStart | output | 1 | Starts the external tag engine |
| macLen | output | SIZE_W | Length of the region from address 0 |
| macDone | input | 1 | Engine result valid |
| macTag | input | TAG_W | Engine result tag |
| cpuRelease | output | 1 | CPU allowed out of reset |
| bootDone | output | 1 | Boot check finished |
| bootPass | output | 1 | Boot check passed |
| bootFailed | output | 1 | Boot failed by check or by report |
| keysUsable | output | 1 | Keys tied to boot may be used |

## Verification
A wrong persistent value shows at the next boot and not before. A stale counter or a corrupt reference turns a pass into a fail, and a wrong length shows on `macLen` while `macStart` is high. A state error in the boot sequencer shows sooner: `cpuRelease` moves in the wrong cycle relative to `macStart` and `bootDone`. A window error shows in the `rspErr` of the first boot-ok or boot-failure after the check, one cycle after that command. A behavioural model in the bench follows every output on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam logic [1:0] OP_DEFINE   = 2'd0;
  localparam logic [1:0] OP_UPDATE   = 2'd1;
  localparam logic [1:0] OP_BOOTOK   = 2'd2;
  localparam logic [1:0] OP_BOOTFAIL = 2'd3;

  localparam logic [1:0] MODE_PAR    = 2'd0;
  localparam logic [1:0] MODE_SEQ    = 2'd1;
  localparam logic [1:0] MODE_STRICT = 2'd2;

  localparam logic [2:0] ERR_OK     = 3'd0;
  localparam logic [2:0] ERR_LOCKED = 3'd1;
  localparam logic [2:0] ERR_STALE  = 3'd2;
  localparam logic [2:0] ERR_SEQ    = 3'd3;
  localparam logic [2:0] ERR_MODE   = 3'd4;

  // strobes from the boot sequencer to the policy datapath
  typedef struct packed {
    logic learnRef;
    logic setHold;
    logic windowOpen;
  } ctrlStrobe_t;
endpackage

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int TAG_W  = 128,
  parameter int SIZE_W = 20,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdMode,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [TAG_W-1:0]  macTag,
  input  ctrlStrobe_t       strobe,
  output logic [1:0]        cfgMode,
  output logic [SIZE_W-1:0] cfgSize,
  output logic              strictLock,
  output logic              holdLatch,
  output logic              refValid,
  output logic [CNT_W-1:0]  refCount,
  output logic              tagMatch,
  output logic              bootOkAcc,
  output logic              bootFailAcc,
  output logic              rspValid,
  output logic [2:0]        rspErr
);
  logic [TAG_W-1:0] refTag;
  logic             acceptDefine;
  logic             acceptUpdate;
  logic [2:0]       errNext;
  logic             live;

  assign live     = cmdValid && porN && rstN;
  assign tagMatch = (macTag == refTag);  // whole tag, single verdict

  always_comb begin
    errNext      = ERR_OK;
    acceptDefine = 1'b0;
    acceptUpdate = 1'b0;
    bootOkAcc    = 1'b0;
    bootFailAcc  = 1'b0;
    if (live) begin
      case (cmdOp)
        OP_DEFINE: begin
          if (strictLock)               errNext = ERR_LOCKED;
          else if (cmdMode > MODE_STRICT) errNext = ERR_MODE;
          else                          acceptDefine = 1'b1;
        end
        OP_UPDATE: begin
          if (cmdCount > refCount) acceptUpdate = 1'b1;
          else                     errNext = ERR_STALE;
        end
        OP_BOOTOK: begin
          if (strobe.windowOpen) bootOkAcc = 1'b1;
          else                   errNext = ERR_SEQ;
        end
        default: begin
          if (strobe.windowOpen) bootFailAcc = 1'b1;
          else                   errNext = ERR_SEQ;
        end
      endcase
    end
  end

  // persistent policy: cleared only by power-on reset
  always_ff @(posedge clk) begin
    if (!porN) begin
      cfgMode    <= MODE_PAR;
      cfgSize    <= '0;
      strictLock <= 1'b0;
      holdLatch  <= 1'b0;
      refValid   <= 1'b0;
      refCount   <= '0;
      refTag     <= '0;
    end else begin
      if (strobe.learnRef) begin
        refTag   <= macTag;
        refValid <= 1'b1;
      end
      if (strobe.setHold) holdLatch <= 1'b1;
      if (acceptDefine) begin
        cfgMode    <= cmdMode;
        cfgSize    <= cmdSize;
        strictLock <= (cmdMode == MODE_STRICT);
      end
      if (acceptUpdate) begin
        refTag   <= cmdTag;
        refCount <= cmdCount;
        refValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      rspValid <= 1'b0;
      rspErr   <= ERR_OK;
    end else begin
      rspValid <= cmdValid;
      if (cmdValid) rspErr <= errNext;
    end
  end
endmodule

// File: rtl/sbc_control.sv
module sbc_control
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        holdLatch,
  input  logic        refValid,
  input  logic        tagMatch,
  input  logic        macDone,
  input  logic        bootOkAcc,
  input  logic        bootFailAcc,
  output ctrlStrobe_t strobe,
  output logic        macStart,
  output logic        cpuRelease,
  output logic        bootDone,
  output logic        bootPass,
  output logic        bootFailed,
  output logic        keysUsable
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT, S_DONE, S_HOLD} bootState_e;

  bootState_e state;
  logic [1:0] runMode;
  logic       window;
  logic       checkPass;
  logic       finish;

  assign checkPass = !refValid || tagMatch;
  assign finish    = (state == S_WAIT) && macDone;
  assign macStart  = (state == S_START);

  always_comb begin
    strobe.learnRef   = finish && !refValid;
    strobe.setHold    = finish && !checkPass && (runMode == MODE_STRICT);
    strobe.windowOpen = window;
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      state      <= S_IDLE;
      runMode    <= MODE_PAR;
      window     <= 1'b0;
      cpuRelease <= 1'b0;
      bootDone   <= 1'b0;
      bootPass   <= 1'b0;
      bootFailed <= 1'b0;
      keysUsable <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (holdLatch) begin
            state      <= S_HOLD;
            bootDone   <= 1'b1;
            bootFailed <= 1'b1;
          end else begin
            state      <= S_START;
            runMode    <= cfgMode;
            cpuRelease <= (cfgMode == MODE_PAR);
          end
        end
        S_START: state <= S_WAIT;
        S_WAIT: begin
          if (macDone) begin
            bootDone   <= 1'b1;
            bootPass   <= checkPass;
            bootFailed <= !checkPass;
            keysUsable <= checkPass;
            if (!checkPass && runMode == MODE_STRICT) begin
              state <= S_HOLD;
            end else begin
              state      <= S_DONE;
              window     <= 1'b1;
              cpuRelease <= 1'b1;
            end
          end
        end
        S_DONE: begin
          if (bootOkAcc) window <= 1'b0;
          if (bootFailAcc) begin
            window     <= 1'b0;
            bootFailed <= 1'b1;
            keysUsable <= 1'b0;
          end
        end
        default: cpuRelease <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/secure_boot_ctrl.sv
module secure_boot_ctrl
  import sbc_pkg::*;
#(
  parameter int TAG_W  = 128,
  parameter int SIZE_W = 20,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdMode,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic              rspValid,
  output logic [2:0]        rspErr,
  output logic              macStart,
  output logic [SIZE_W-1:0] macLen,
  input  logic              macDone,
  input  logic [TAG_W-1:0]  macTag,
  output logic              cpuRelease,
  output logic              bootDone,
  output logic              bootPass,
  output logic              bootFailed,
  output logic              keysUsable
);
  ctrlStrobe_t      strobe;
  logic [1:0]       cfgMode;
  logic [SIZE_W-1:0] cfgSize;
  logic             strictLock;
  logic             holdLatch;
  logic             refValid;
  logic [CNT_W-1:0] refCount;
  logic             tagMatch;
  logic             bootOkAcc;
  logic             bootFailAcc;

  assign macLen = cfgSize;

  sbc_datapath #(.TAG_W(TAG_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .porN(porN), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMode(cmdMode), .cmdSize(cmdSize),
    .cmdTag(cmdTag), .cmdCount(cmdCount), .macTag(macTag), .strobe(strobe),
    .cfgMode(cfgMode), .cfgSize(cfgSize), .strictLock(strictLock),
    .holdLatch(holdLatch), .refValid(refValid), .refCount(refCount),
    .tagMatch(tagMatch), .bootOkAcc(bootOkAcc), .bootFailAcc(bootFailAcc),
    .rspValid(rspValid), .rspErr(rspErr)
  );

  sbc_control uCtrl (
    .clk(clk), .porN(porN), .rstN(rstN),
    .cfgMode(cfgMode), .holdLatch(holdLatch), .refValid(refValid),
    .tagMatch(tagMatch), .macDone(macDone),
    .bootOkAcc(bootOkAcc), .bootFailAcc(bootFailAcc),
    .strobe(strobe), .macStart(macStart), .cpuRelease(cpuRelease),
    .bootDone(bootDone), .bootPass(bootPass), .bootFailed(bootFailed),
    .keysUsable(keysUsable)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
  import sbc_pkg::*;
#(
  parameter int SIZE_W = 20,
  parameter int CNT_W  = 28
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [CNT_W-1:0]  cmdCount,
  input logic              rspValid,
  input logic [2:0]        rspErr,
  input logic              macStart,
  input logic              cpuRelease,
  input logic              bootFailed,
  input logic              keysUsable,
  input logic              holdLatch,
  input logic              strictLock,
  input logic [CNT_W-1:0]  refCount,
  input logic [1:0]        cfgMode,
  input logic [SIZE_W-1:0] cfgSize
);
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!porN || !rstN)
    macStart |=> !macStart);

  assert_strict_frozen_R4: assert property (@(posedge clk) disable iff (!porN)
    strictLock |=> strictLock && $stable(cfgMode) && $stable(cfgSize));

  assert_held_no_release_R6: assert property (@(posedge clk) disable iff (!porN || !rstN)
    holdLatch |-> !cpuRelease);

  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!porN)
    holdLatch |=> holdLatch);

  assert_update_counter_R8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (rspValid && rspErr == ERR_OK && $past(cmdOp) == OP_UPDATE) |-> refCount == $past(cmdCount));

  assert_stale_keeps_R8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (rspValid && rspErr == ERR_STALE) |-> $stable(refCount));

  assert_fail_report_R9: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (rspValid && rspErr == ERR_OK && $past(cmdOp) == OP_BOOTFAIL) |-> bootFailed && !keysUsable);

  assert_one_response_R12: assert property (@(posedge clk) disable iff (!porN || !rstN)
    cmdValid |=> rspValid);
endmodule

bind secure_boot_ctrl sbc_checker #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .porN(porN), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdCount(cmdCount), .rspValid(rspValid), .rspErr(rspErr), .macStart(macStart),
  .cpuRelease(cpuRelease), .bootFailed(bootFailed), .keysUsable(keysUsable),
  .holdLatch(holdLatch), .strictLock(strictLock), .refCount(refCount),
  .cfgMode(cfgMode), .cfgSize(cfgSize)
);

// File: tb/tb_secure_boot_ctrl.sv
module tb_secure_boot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 128;
  localparam int SIZE_W = 20;
  localparam int CNT_W = 28;
  localparam int ENG_LAT = 3;

  logic clk = 0;
  logic porN = 0, rstN = 0;
  logic cmdValid = 0;
  logic [1:0] cmdOp = 0, cmdMode = 0;
  logic [SIZE_W-1:0] cmdSize = 0;
  logic [TAG_W-1:0] cmdTag = 0;
  logic [CNT_W-1:0] cmdCount = 0;
  logic rspValid, macStart, cpuRelease, bootDone, bootPass, bootFailed, keysUsable;
  logic [2:0] rspErr;
  logic [SIZE_W-1:0] macLen;
  logic macDone = 0;
  logic [TAG_W-1:0] macTag = 0;
  logic [TAG_W-1:0] engTag = 0;

  int tests = 0, fails = 0, engCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_boot_ctrl #(.TAG_W(TAG_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) dut (.*);

  // tag engine stand-in: result ENG_LAT falling edges after a start
  always @(negedge clk) begin
    macDone <= 1'b0;
    if (engCnt > 0) begin
      engCnt <= engCnt - 1;
      if (engCnt == 1) begin macDone <= 1'b1; macTag <= engTag; end
    end
    if (macStart) engCnt <= ENG_LAT;
  end

  // behavioural reference model
  bit [1:0] mMode; bit [SIZE_W-1:0] mSize; bit mLock, mHold, mRefV;
  bit [TAG_W-1:0] mRef; bit [CNT_W-1:0] mCnt;
  int mState; bit [1:0] mRun;
  bit mRel, mDone, mPass, mFail, mKeys, mWin, mRspV; bit [2:0] mRspE;

  task automatic volReset();
    mState = 0; mRun = 0; mRel = 0; mDone = 0; mPass = 0; mFail = 0;
    mKeys = 0; mWin = 0; mRspV = 0; mRspE = 0;
  endtask

  always @(posedge clk) begin
    bit pass, okA, failA, learn; bit [2:0] e;
    if (!porN) begin
      mMode = 0; mSize = 0; mLock = 0; mHold = 0; mRefV = 0; mRef = 0; mCnt = 0;
      volReset();
    end else if (!rstN) volReset();
    else begin
      pass = !mRefV || (macTag == mRef);
      okA = 0; failA = 0; learn = 0;
      mRspV = cmdValid;
      if (cmdValid) begin
        e = 0;
        if (cmdOp == 0) begin
          if (mLock) e = 1; else if (cmdMode == 3) e = 4;
          else begin mMode = cmdMode; mSize = cmdSize; mLock = (cmdMode == 2); end
        end else if (cmdOp == 1) begin
          if (cmdCount > mCnt) begin mRef = cmdTag; mCnt = cmdCount; mRefV = 1; end
          else e = 2;
        end else begin
          if (!mWin) e = 3; else if (cmdOp == 2) okA = 1; else failA = 1;
        end
        mRspE = e;
      end
      case (mState)
        0: if (mHold) begin mState = 4; mDone = 1; mFail = 1; end
           else begin mState = 1; mRun = mMode; mRel = (mMode == 0); end
        1: mState = 2;
        2: if (macDone) begin
             mDone = 1; mPass = pass; mFail = !pass; mKeys = pass;
             learn = !mRefV;
             if (!pass && mRun == 2) begin mState = 4; mHold = 1; end
             else begin mState = 3; mWin = 1; mRel = 1; end
           end
        3: begin
             if (okA) mWin = 0;
             if (failA) begin mWin = 0; mFail = 1; mKeys = 0; end
           end
        default: mRel = 0;
      endcase
      if (learn && !(cmdValid && cmdOp == 1 && cmdCount > mCnt)) begin
        mRef = macTag; mRefV = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (!finished) begin
    tests++;
    if (cpuRelease !== mRel || macStart !== (mState == 1) || macLen !== mSize ||
        bootDone !== mDone || bootPass !== mPass || bootFailed !== mFail ||
        keysUsable !== mKeys || rspValid !== mRspV || rspErr !== mRspE) begin
      fails++;
      $display("FAIL R12 model compare: actual rel=%0b st=%0b len=%0d dn=%0b ps=%0b fl=%0b ky=%0b rv=%0b re=%0d expected rel=%0b st=%0b len=%0d dn=%0b ps=%0b fl=%0b ky=%0b rv=%0b re=%0d",
        cpuRelease, macStart, macLen, bootDone, bootPass, bootFailed, keysUsable, rspValid, rspErr,
        mRel, (mState == 1), mSize, mDone, mPass, mFail, mKeys, mRspV, mRspE);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [TAG_W-1:0] act, input logic [TAG_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [1:0] mode, input logic [SIZE_W-1:0] size,
                         input logic [TAG_W-1:0] tag, input logic [CNT_W-1:0] cnt, output logic [2:0] err);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdMode = mode; cmdSize = size; cmdTag = tag; cmdCount = cnt;
    @(negedge clk);
    cmdValid = 0;
    chk(rspValid === 1'b1, "R12 response strobe", rspValid, 1);
    err = rspErr;
  endtask

  task automatic pulseReset();
    @(negedge clk) rstN = 0;
    @(negedge clk) rstN = 1;
  endtask

  task automatic waitDone(output bit early, output int starts);
    early = 0; starts = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (macStart) starts++;
      if (cpuRelease && !bootDone) early = 1;
      if (bootDone) break;
    end
  endtask

  task automatic softBoot(output bit early, output int starts);
    pulseReset();
    waitDone(early, starts);
  endtask

  initial begin
    logic [2:0] e; bit early; int starts;
    logic [TAG_W-1:0] tA, tB, tC, tD;
    tA = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    tB = 128'h13579bdf_2468ace0_fedcba98_76543210;
    tC = 128'hdeadbeef_00c0ffee_11223344_55667788;
    tD = 128'h0a0b0c0d_10203040_a1b2c3d4_99887766;

    repeat (3) @(negedge clk);
    chk(cpuRelease === 0 && macStart === 0 && rspValid === 0 && bootDone === 0 && keysUsable === 0,
        "R12 reset state", {cpuRelease, macStart, rspValid, bootDone}, 0);
    porN = 1;

    // first boot: parallel default, no reference stored -> learn
    engTag = tA;
    softBoot(early, starts);
    chk(early, "R2 parallel release before done", early, 1);
    chk(starts == 1, "R1 single start pulse", starts, 1);
    chk(bootPass === 1 && keysUsable === 1, "R7 learn on first boot passes", bootPass, 1);
    sendCmd(2, 0, 0, 0, 0, e);
    chk(e == 0, "R9 boot-ok after check", e, 0);
    sendCmd(2, 0, 0, 0, 0, e);
    chk(e == 3, "R9 second boot-ok rejected", e, 3);

    // sequential mode, length 100
    sendCmd(0, 1, 100, 0, 0, e);
    chk(e == 0, "R1 define accepted", e, 0);
    pulseReset();
    sendCmd(3, 0, 0, 0, 0, e);
    chk(e == 3, "R9 boot-failure during check", e, 3);
    chk(cpuRelease === 0 && bootDone === 0, "R3 held during check", cpuRelease, 0);
    chk(macLen == 100, "R1 length from define", macLen, 100);
    waitDone(early, starts);
    chk(!early && cpuRelease === 1 && bootPass === 1, "R3 released after pass", cpuRelease, 1);

    // LSB flipped: learned reference is compared on full width
    engTag = tA ^ 128'h1;
    softBoot(early, starts);
    chk(bootPass === 0, "R10 lsb difference fails", bootPass, 0);
    chk(bootFailed === 1 && keysUsable === 0 && cpuRelease === 1, "R3 released on fail with status",
        {bootFailed, keysUsable, cpuRelease}, 3'b101);
    sendCmd(3, 0, 0, 0, 0, e);
    chk(e == 0, "R9 boot-failure accepted", e, 0);
    sendCmd(3, 0, 0, 0, 0, e);
    chk(e == 3, "R9 repeated boot-failure rejected", e, 3);

    // counter rules
    sendCmd(1, 0, 0, tB, 5, e);
    chk(e == 0, "R8 higher counter accepted", e, 0);
    sendCmd(1, 0, 0, tC, 5, e);
    chk(e == 2, "R8 equal counter stale", e, 2);
    sendCmd(1, 0, 0, tC, 3, e);
    chk(e == 2, "R8 lower counter stale", e, 2);
    engTag = tB;
    softBoot(early, starts);
    chk(bootPass === 1 && keysUsable === 1, "R8 stale updates left reference", bootPass, 1);
    sendCmd(3, 0, 0, 0, 0, e);
    chk(e == 0 && bootFailed === 1 && keysUsable === 0, "R9 failure report clears keys",
        {e, bootFailed, keysUsable}, 5'b00010);

    // bad mode
    sendCmd(0, 3, 7, 0, 0, e);
    chk(e == 4 && macLen == 100, "R11 bad mode rejected", {e, macLen}, {3'd4, 20'd100});

    // strict mode lock
    sendCmd(0, 2, 200, 0, 0, e);
    chk(e == 0, "R4 strict define accepted", e, 0);
    sendCmd(0, 1, 50, 0, 0, e);
    chk(e == 1, "R4 later define locked", e, 1);
    softBoot(early, starts);
    chk(macLen == 200 && !early && cpuRelease === 1 && bootPass === 1, "R4 size and mode kept",
        macLen, 200);

    // strict mode still takes a reference update
    sendCmd(1, 0, 0, tD, 9, e);
    chk(e == 0, "R5 update in strict mode", e, 0);
    engTag = tD;
    softBoot(early, starts);
    chk(bootPass === 1 && cpuRelease === 1, "R5 new reference used", bootPass, 1);

    // MSB flipped in strict mode: permanent hold
    engTag = tD ^ {1'b1, {(TAG_W-1){1'b0}}};
    softBoot(early, starts);
    chk(bootPass === 0 && cpuRelease === 0, "R10 msb difference fails", {bootPass, cpuRelease}, 0);
    repeat (4) @(negedge clk);
    chk(cpuRelease === 0 && bootFailed === 1, "R6 held after strict fail", cpuRelease, 0);
    engTag = tD;
    softBoot(early, starts);
    chk(cpuRelease === 0 && starts == 0, "R6 soft reset keeps hold", {cpuRelease, starts[3:0]}, 0);
    sendCmd(1, 0, 0, tD, 10, e);
    sendCmd(0, 0, 10, 0, 0, e);
    chk(e == 1, "R6 define still locked", e, 1);
    softBoot(early, starts);
    chk(cpuRelease === 0 && starts == 0, "R6 commands do not clear hold", cpuRelease, 0);

    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule